// File: doc/BRIEF.md
# IO Virtual Address Translation Unit

This block translates bus addresses issued by devices into physical memory addresses. Software programs a translation window (a base and a mask), a page size, and the physical base of a page directory held in memory. Every translation request whose address falls inside the enabled window is looked up by page. A small fully associative cache of recent translations answers repeated requests. On a miss, the unit fetches one 64-bit directory entry through a simple memory read port.

A purge command invalidates every cached translation inside a naturally aligned range. Software issues it after changing directory entries or the configuration. Requests that miss the window, meet an invalid configuration or hit an entry without its valid flag get a fault response.

Top module: `iova_xlate`

## Requirements
- R1: Register reads return the last value written. The offsets are 0x300 window base, 0x308 window mask, 0x310 purge command, 0x318 page-size code and 0x320 directory base. Any other offset reads as zero, and every register resets to zero.
- R2: Bit 0 of the window base is the translation enable. While it is 0, every request gets a fault response and no directory read is issued.
- R3: A request is inside the window when (addr AND mask) equals (base with bit 0 cleared, AND mask). A request outside the window faults with no directory read.
- R4: Page-size codes 0, 1, 2 and 3 give page shifts of 12, 13, 14 and 16 bits. Any other code makes every request fault with no directory read.
- R5: Each request gets exactly one response, a single-cycle pulse on rsp_valid. A cache hit responds in the second cycle after acceptance.
- R6: A cache miss issues exactly one directory read at dir_base + 8*((addr - base) >> shift). The read address is held until mem_rd_ack, and no request is accepted while the read is pending.
- R7: An entry with bit 63 clear produces a fault with rsp_paddr zero. Such an entry is not cached, so a repeat request reads the directory again.
- R8: A successful response carries entry bits [62:shift] as the page address, with the low shift bits copied from the bus address. A fault response always has rsp_paddr zero.
- R9: Writing the purge register with an address OR k (k in bits [5:0], at least 6 in effect) invalidates every cached page whose address lies in the 2^k-byte aligned range holding that address. A later request to such a page reads the directory again. Pages outside the range remain cached. req_ready is low in the purge-write cycle.
- R10: The cache holds N_ENT valid translations and replaces them round-robin. A cached page responds with no directory read. After N_ENT further distinct fills, the oldest page has been evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational on reg_addr |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_addr | input | 64 | Bus address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 64 | Translated physical address |
| mem_rd_valid | output | 1 | Directory read pending |
| mem_rd_addr | output | 64 | Directory entry address |
| mem_rd_ack | input | 1 | Directory read data valid |
| mem_rd_data | input | 64 | Directory entry |

## Verification
The assertions assume that the directory base is 8-byte aligned. They also assume that the memory side raises mem_rd_ack only while a read is pending, and for one cycle. The bench writes only aligned directory bases. Its memory model answers each pending read exactly once, two cycles after it appears, and then drops the acknowledge. The stimulus changes the page size or window only after a purge of the whole space. Tags therefore never mix across page sizes.

// File: rtl/iova_xlate.sv
module iova_xlate #(
  parameter int N_ENT = 8,
  localparam int RR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [63:0] rsp_paddr,
  output logic        mem_rd_valid,
  output logic [63:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [63:0] mem_rd_data
);
  localparam logic [11:0] OFF_BASE  = 12'h300;
  localparam logic [11:0] OFF_MASK  = 12'h308;
  localparam logic [11:0] OFF_PURGE = 12'h310;
  localparam logic [11:0] OFF_PSZ   = 12'h318;
  localparam logic [11:0] OFF_DIR   = 12'h320;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FETCH} state_t;
  state_t state;

  logic [63:0] win_base, win_mask, purge_r, psz, dir_base;
  logic [63:0] cur_addr;
  logic        drop_fill;

  logic [N_ENT-1:0] c_vld;
  logic [63:0]      c_tag [N_ENT];
  logic [63:0]      c_pg  [N_ENT];
  logic [RR_W-1:0]  rr;

  logic [5:0]  sh;
  logic [63:0] pmask, vpage, base_clr, dir_idx;
  logic        psz_ok, in_win, hit;
  logic [63:0] hit_pg;

  always_comb begin
    case (psz[1:0])
      2'd0: sh = 6'd12;
      2'd1: sh = 6'd13;
      2'd2: sh = 6'd14;
      default: sh = 6'd16;
    endcase
  end

  assign psz_ok   = (psz[63:2] == '0);
  assign pmask    = (64'd1 << sh) - 64'd1;
  assign vpage    = cur_addr & ~pmask;
  assign base_clr = {win_base[63:1], 1'b0};
  assign in_win   = win_base[0] && psz_ok && ((cur_addr & win_mask) == (base_clr & win_mask));
  assign dir_idx  = (cur_addr - base_clr) >> sh;

  always_comb begin
    hit    = 1'b0;
    hit_pg = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (c_vld[i] && c_tag[i] == vpage) begin
        hit    = 1'b1;
        hit_pg = c_pg[i];
      end
    end
  end

  logic        purge_we;
  logic [63:0] pr_mask, pr_base;
  assign purge_we = reg_we && (reg_addr == OFF_PURGE);
  assign pr_mask  = ((64'd1 << reg_wdata[5:0]) - 64'd1) | 64'h3F;
  assign pr_base  = reg_wdata & ~pr_mask;

  assign req_ready    = (state == S_IDLE) && !purge_we;
  assign mem_rd_valid = (state == S_FETCH);
  assign mem_rd_addr  = dir_base + (dir_idx << 3);

  always_comb begin
    case (reg_addr)
      OFF_BASE:  reg_rdata = win_base;
      OFF_MASK:  reg_rdata = win_mask;
      OFF_PURGE: reg_rdata = purge_r;
      OFF_PSZ:   reg_rdata = psz;
      OFF_DIR:   reg_rdata = dir_base;
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_base <= '0;
      win_mask <= '0;
      purge_r  <= '0;
      psz      <= '0;
      dir_base <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFF_BASE:  win_base <= reg_wdata;
        OFF_MASK:  win_mask <= reg_wdata;
        OFF_PURGE: purge_r  <= reg_wdata;
        OFF_PSZ:   psz      <= reg_wdata;
        OFF_DIR:   dir_base <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      drop_fill <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      c_vld     <= '0;
      rr        <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        c_tag[i] <= '0;
        c_pg[i]  <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (purge_we) begin
        for (int i = 0; i < N_ENT; i++)
          if ((c_tag[i] & ~pr_mask) == pr_base) c_vld[i] <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          drop_fill <= 1'b0;
          if (req_valid && req_ready) begin
            cur_addr <= req_addr;
            state    <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (!in_win) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            state     <= S_IDLE;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= hit_pg | (cur_addr & pmask);
            state     <= S_IDLE;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (purge_we) drop_fill <= 1'b1;
          if (mem_rd_ack) begin
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
            if (mem_rd_data[63]) begin
              rsp_fault <= 1'b0;
              rsp_paddr <= ({1'b0, mem_rd_data[62:0]} & ~pmask) | (cur_addr & pmask);
              if (!drop_fill && !purge_we) begin
                c_vld[rr] <= 1'b1;
                c_tag[rr] <= vpage;
                c_pg[rr]  <= {1'b0, mem_rd_data[62:0]} & ~pmask;
                rr        <= (rr == RR_W'(N_ENT - 1)) ? '0 : rr + 1'b1;
              end
            end else begin
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [11:0] reg_addr,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [63:0] rsp_paddr,
  input logic        mem_rd_valid,
  input logic [63:0] mem_rd_addr,
  input logic        mem_rd_ack
);
  a_r9_purge_blocks_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 12'h310) |-> !req_ready);

  a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 64'd0));

  a_r6_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r6_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ack) |=> !mem_rd_valid);

  a_r5_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'd0));
endmodule

bind iova_xlate iova_xlate_chk u_chk (.*);

// File: tb/iova_xlate_test.sv
module iova_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_paddr;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [63:0] mem_rd_data = '0;

  always #2.5 clk = ~clk;

  iova_xlate uut (.*);

  localparam logic [63:0] WIN  = 64'h0000_0000_4000_0000;
  localparam logic [63:0] MSK  = 64'hFFFF_FFFF_C000_0000;
  localparam logic [63:0] DIRB = 64'h0000_0000_1000_0000;

  logic [63:0] dir [64];
  int nreads = 0;
  logic [63:0] last_rd = '0;
  int lat = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [63:0] pg(int i);
    return 64'h0000_0020_0000_0000 + 64'(i) * 64'h3_0000;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_valid && mem_rd_ack) begin
      nreads  <= nreads + 1;
      last_rd <= mem_rd_addr;
    end
    if (mem_rd_valid && !mem_rd_ack) begin
      if (lat == 1) begin
        lat <= 0;
        mem_rd_ack <= 1'b1;
        mem_rd_data <= ((mem_rd_addr - DIRB) >> 3) < 64 ? dir[(mem_rd_addr - DIRB) >> 3] : 64'd0;
      end else lat <= lat + 1;
    end else mem_rd_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic xl(input logic [63:0] a, output logic f, output logic [63:0] p, output int rd);
    int r0;
    @(negedge clk);
    r0 = nreads;
    req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    f = rsp_fault; p = rsp_paddr;
    rd = nreads - r0;
  endtask

  function automatic int shf(int c);
    return (c == 3) ? 16 : 12 + c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic f; logic [63:0] p, a, e; int rd, sh;
    for (int i = 0; i < 64; i++) dir[i] = ((i % 5) == 3) ? pg(i) : (64'h8000_0000_0000_0000 | pg(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and readback
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); reg_addr = 12'h300 + 12'(k * 8); #1;
      chk(reg_rdata == 0, "R1 reset", reg_rdata, 0);
    end
    wr(12'h300, WIN); wr(12'h308, MSK); wr(12'h318, 64'd0); wr(12'h320, DIRB);
    wr(12'h310, 64'd63);
    for (int k = 0; k < 5; k++) begin
      logic [63:0] ex;
      ex = (k == 0) ? WIN : (k == 1) ? MSK : (k == 2) ? 64'd63 : (k == 3) ? 64'd0 : DIRB;
      @(negedge clk); reg_addr = 12'h300 + 12'(k * 8); #1;
      chk(reg_rdata == ex, "R1 readback", reg_rdata, ex);
    end
    @(negedge clk); reg_addr = 12'h328; #1;
    chk(reg_rdata == 0, "R1 unmapped", reg_rdata, 0);

    // R2 disabled
    xl(WIN + 64'h1000, f, p, rd);
    chk(f && rd == 0, "R2 disabled", {63'(rd), f}, 64'd1);
    wr(12'h300, WIN | 64'd1);

    // R4 R6 R7 R8 sweep of page sizes
    for (int c = 0; c < 4; c++) begin
      sh = shf(c);
      wr(12'h318, 64'(c));
      wr(12'h310, 64'd63);
      for (int pass = 0; pass < 2; pass++) begin
        for (int i = 0; i < 7; i++) begin
          a = WIN + (64'(i) << sh) + (64'(i * 37 + 5) & ((64'd1 << sh) - 1));
          xl(a, f, p, rd);
          if ((i % 5) == 3) begin
            chk(f && p == 0, "R7 invalid entry fault", p, 0);
            chk(rd == 1, "R7 invalid not cached", 64'(rd), 1);
          end else begin
            e = pg(i) | (a & ((64'd1 << sh) - 1));
            chk(!f && p == e, "R4 R8 translated address", p, e);
            chk(rd == (pass == 0 ? 1 : 0), "R10 hit no read", 64'(rd), pass == 0 ? 1 : 0);
          end
          if (pass == 0)
            chk(last_rd == DIRB + 64'(i) * 8, "R6 directory address", last_rd, DIRB + 64'(i) * 8);
        end
      end
    end

    // R4 invalid code
    wr(12'h318, 64'd5);
    xl(WIN, f, p, rd);
    chk(f && rd == 0, "R4 invalid code", {63'(rd), f}, 64'd1);
    wr(12'h318, 64'd0);
    wr(12'h310, 64'd63);

    // R3 outside window
    xl(64'h0000_0000_9000_0000, f, p, rd);
    chk(f && rd == 0 && p == 0, "R3 outside window", {63'(rd), f}, 64'd1);
    xl(WIN - 64'h1000, f, p, rd);
    chk(f && rd == 0, "R3 below window", {63'(rd), f}, 64'd1);

    // R10 round-robin eviction
    begin
      int lst [9] = '{0, 1, 2, 4, 5, 6, 7, 9, 10};
      foreach (lst[j]) xl(WIN + (64'(lst[j]) << 12), f, p, rd);
      xl(WIN + (64'd1 << 12), f, p, rd);
      chk(!f && rd == 0, "R10 second entry kept", 64'(rd), 0);
      xl(WIN, f, p, rd);
      chk(!f && rd == 1 && p == pg(0), "R10 oldest evicted", 64'(rd), 1);
    end

    // R9 purge ranges
    wr(12'h310, 64'd63);
    xl(WIN + (64'd20 << 12), f, p, rd);
    chk(rd == 1 && p == pg(20), "R9 initial fill", p, pg(20));
    dir[20] = 64'h8000_0000_0000_0000 | pg(50);
    xl(WIN + (64'd20 << 12) + 64'h10, f, p, rd);
    chk(rd == 0 && p == (pg(20) | 64'h10), "R9 stale before purge", p, pg(20) | 64'h10);
    wr(12'h310, (WIN + (64'd21 << 12)) | 64'd12);
    xl(WIN + (64'd20 << 12), f, p, rd);
    chk(rd == 0 && p == pg(20), "R9 outside purge range kept", p, pg(20));
    wr(12'h310, (WIN + (64'd20 << 12)) | 64'd12);
    xl(WIN + (64'd20 << 12), f, p, rd);
    chk(rd == 1 && p == pg(50), "R9 purged refetch", p, pg(50));
    xl(WIN + (64'd2 << 12), f, p, rd);
    wr(12'h310, WIN | 64'd14);
    xl(WIN + (64'd2 << 12), f, p, rd);
    chk(rd == 1, "R9 wide range purge", 64'(rd), 1);

    // R5 hit latency
    begin
      int cyc;
      @(negedge clk);
      req_addr = WIN + (64'd2 << 12); req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      cyc = 0;
      @(negedge clk); req_valid = 1'b0;
      while (!rsp_valid) begin @(negedge clk); cyc++; end
      chk(cyc == 1, "R5 hit latency", 64'(cyc), 1);
      @(negedge clk);
      chk(!rsp_valid, "R5 single pulse", {63'd0, rsp_valid}, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule